// File: doc/BRIEF.md
# Shared Backplane Bus Arbiter with Result Dispatch

This block sits at the centre of a shared backplane bus that several ports use. A port that holds a packet raises its request line. When the bus is idle, the block picks one requester in round-robin order and grants the bus to it. The granted port then streams its packet as wide data beats. The block re-drives each beat onto the common bus, where every other port stores a copy in a pending slot. Each packet carries a sequence tag so that the copies can be matched to their results later.

The block learns the forwarding decision for each packet from a lookup engine. Lookup results come back in packet order. The block pairs each result with the tag of the oldest packet that is still waiting. It then broadcasts a 64-bit result word on a separate, narrower result bus. Each port uses that word to forward or drop the copy it holds. The block keeps a count of packets that still wait for a result. It withholds grants while that count has reached the pending-slot depth, and also while any port signals that its own buffer is full.

The bus controller has two named states:
- IDLE: no packet is on the bus. The transition IDLE->XFER (grant) is taken when at least one port requests, no port asserts backpressure and the pending count is below its limit.
- XFER: the granted port owns the bus. The transition XFER->IDLE (release) is taken on the clock edge at which an end-of-packet beat is accepted.

Top module: `bpbus_central`

## Requirements
- R1: After reset, `gnt`, `bus_valid`, `bus_eop`, `bus_busy` and `res_valid` are all 0. The first packet's sequence tag is 0.
- R2: `gnt` is one-hot or zero. Once a grant is given, `gnt` stays unchanged until the end-of-packet beat is accepted, whatever the request lines do in the meantime. `bus_busy` is 1 exactly while a grant is held.
- R3: A grant goes to the first requesting port found by searching upward from the index after the last granted port, wrapping from N_PORTS-1 to 0. After reset the search starts at port 0. A grant appears on `gnt` (bit i = port i) one cycle after the requests are seen in IDLE.
- R4: A beat with `din_valid`=1 that is accepted while a grant is held appears one cycle later on `bus_valid`/`bus_data`/`bus_eop`, with the packet's sequence tag on `bus_tag`. A cycle with `din_valid`=0, and any beat offered while no grant is held, gives `bus_valid`=0.
- R5: The sequence tag is TAG_W=4 bits wide. It goes up by 1 (modulo 16) for each completed packet.
- R6: On the edge that accepts the end-of-packet beat, `gnt` falls to 0. A waiting requester can be granted on the following edge, so back-to-back packets are separated by exactly one cycle without a grant.
- R7: While any `bp` bit is 1, no new grant is issued.
- R8: While MAX_PEND packets are waiting for a result, no new grant is issued. A result that frees a slot allows a grant on the next edge after that result is accepted.
- R9: A result offered with `lk_valid`=1 while at least one packet is waiting produces, one cycle later, a single-cycle `res_valid` pulse. The word carries the tag of the oldest waiting packet. Field layout: [63:60] tag, [59] forward flag, [58:53] DSCP rewrite, [52:50] CoS rewrite, [49:48] queue select, [47:0] next-hop MAC.
- R10: A result offered while no packet is waiting is ignored. `res_valid` stays 0, and the tag given to the next result is unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req | input | N_PORTS | Per-port bus request |
| bp | input | N_PORTS | Per-port pending-buffer-full backpressure |
| gnt | output | N_PORTS | One-hot grant to the sending port |
| bus_busy | output | 1 | Bus is owned by a sender |
| din | input | DATA_W | Beat data from the granted port |
| din_valid | input | 1 | Beat on `din` is valid |
| din_eop | input | 1 | Beat on `din` is the last of the packet |
| bus_valid | output | 1 | Broadcast beat valid |
| bus_data | output | DATA_W | Broadcast beat data |
| bus_eop | output | 1 | Broadcast beat is end of packet |
| bus_tag | output | 4 | Sequence tag of the broadcast packet |
| lk_valid | input | 1 | Lookup result valid |
| lk_fwd | input | 1 | Forward (1) or drop (0) |
| lk_mac | input | 48 | Next-hop destination MAC rewrite |
| lk_queue | input | 2 | Egress queue select |
| lk_cos | input | 3 | CoS rewrite value |
| lk_dscp | input | 6 | DSCP rewrite value |
| res_valid | output | 1 | Result word valid |
| res_word | output | 64 | Broadcast result word |

## Verification
The hardest condition to reach from the ports is a full pending count. Reaching it needs MAX_PEND complete packets with no result returned in between. A request must then be held across the edge where a freeing result lands, and the grant must appear only on the edge after. A directed phase fills the count exactly and checks the grant one cycle after the freeing result. A seeded random phase mixes request masks, packet lengths, idle gaps inside packets and result timing, so that the count keeps moving between empty and full. The random phase also offers results while nothing is waiting.

// File: rtl/bpbus_pkg.sv
package bpbus_pkg;
    localparam int TAG_W = 4;
    localparam int RES_W = 64;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_XFER = 1'b1
    } bus_state_t;

    typedef struct packed {
        logic [TAG_W-1:0] tag;
        logic             fwd;
        logic [5:0]       dscp;
        logic [2:0]       cos;
        logic [1:0]       queue;
        logic [47:0]      mac;
    } res_word_t;
endpackage

// File: rtl/bpbus_rr_pick.sv
module bpbus_rr_pick #(
    parameter int N  = 4,
    parameter int PW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  req,
    input  logic [PW-1:0] last,
    output logic          any,
    output logic [PW-1:0] win_idx,
    output logic [N-1:0]  win_oh
);
    always_comb begin
        any     = 1'b0;
        win_idx = '0;
        for (int k = N; k >= 1; k--) begin
            int idx;
            idx = (int'(last) + k) % N;
            if (req[idx]) begin
                any     = 1'b1;
                win_idx = PW'(idx);
            end
        end
        win_oh = any ? (N'(1) << win_idx) : '0;
    end
endmodule

// File: rtl/bpbus_fsm.sv
module bpbus_fsm
    import bpbus_pkg::*;
#(
    parameter int N_PORTS = 4,
    parameter int DATA_W  = 256
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_PORTS-1:0] req,
    input  logic               allow,
    input  logic [DATA_W-1:0]  din,
    input  logic               din_valid,
    input  logic               din_eop,
    input  logic [TAG_W-1:0]   seq_tag,
    output logic [N_PORTS-1:0] gnt,
    output logic               busy,
    output logic               pkt_done,
    output logic               bus_valid,
    output logic [DATA_W-1:0]  bus_data,
    output logic               bus_eop,
    output logic [TAG_W-1:0]   bus_tag
);
    localparam int PW = (N_PORTS > 1) ? $clog2(N_PORTS) : 1;

    bus_state_t          state, state_nx;
    logic [PW-1:0]       last_idx;
    logic                any_req;
    logic [PW-1:0]       win_idx;
    logic [N_PORTS-1:0]  win_oh;
    logic                do_grant;
    logic                accept;

    bpbus_rr_pick #(.N(N_PORTS), .PW(PW)) rr_i (
        .req     (req),
        .last    (last_idx),
        .any     (any_req),
        .win_idx (win_idx),
        .win_oh  (win_oh)
    );

    assign accept   = (state == ST_XFER) && din_valid;
    assign pkt_done = accept && din_eop;
    assign do_grant = (state == ST_IDLE) && any_req && allow;
    assign busy     = (state == ST_XFER);

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (do_grant) state_nx = ST_XFER;
            ST_XFER: if (pkt_done) state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gnt       <= '0;
            last_idx  <= PW'(N_PORTS - 1);
            bus_valid <= 1'b0;
            bus_data  <= '0;
            bus_eop   <= 1'b0;
            bus_tag   <= '0;
        end else begin
            if (do_grant) begin
                gnt      <= win_oh;
                last_idx <= win_idx;
            end else if (pkt_done) begin
                gnt <= '0;
            end
            bus_valid <= accept;
            bus_eop   <= pkt_done;
            if (accept) begin
                bus_data <= din;
                bus_tag  <= seq_tag;
            end
        end
    end

    p_gnt_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt));
    p_gnt_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt != '0) && !(din_valid && din_eop) |=> $stable(gnt));
    p_eop_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt != '0) && din_valid && din_eop |=> (gnt == '0));
    p_no_grant_blocked_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt == '0) && !allow |=> (gnt == '0));
    p_bus_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt == '0) |=> !bus_valid);
endmodule

// File: rtl/bpbus_pend_track.sv
module bpbus_pend_track
    import bpbus_pkg::*;
#(
    parameter int MAX_PEND = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pkt_done,
    input  logic             lk_valid,
    input  logic             lk_fwd,
    input  logic [47:0]      lk_mac,
    input  logic [1:0]       lk_queue,
    input  logic [2:0]       lk_cos,
    input  logic [5:0]       lk_dscp,
    output logic [TAG_W-1:0] seq_tag,
    output logic             full,
    output logic             res_valid,
    output logic [RES_W-1:0] res_word
);
    localparam int CW = $clog2(MAX_PEND + 1);

    logic [CW-1:0]    cnt;
    logic             take;
    logic [TAG_W-1:0] oldest;
    res_word_t        word_nx;

    assign take   = lk_valid && (cnt != '0);
    assign full   = (cnt == CW'(MAX_PEND));
    assign oldest = seq_tag - TAG_W'(cnt);

    always_comb begin
        word_nx.tag   = oldest;
        word_nx.fwd   = lk_fwd;
        word_nx.dscp  = lk_dscp;
        word_nx.cos   = lk_cos;
        word_nx.queue = lk_queue;
        word_nx.mac   = lk_mac;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt       <= '0;
            seq_tag   <= '0;
            res_valid <= 1'b0;
            res_word  <= '0;
        end else begin
            if (pkt_done) seq_tag <= seq_tag + 1'b1;
            cnt       <= cnt + CW'(pkt_done) - CW'(take);
            res_valid <= take;
            if (take) res_word <= word_nx;
        end
    end

    p_pend_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CW'(MAX_PEND));
    p_ignore_empty_r10: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid && (cnt == '0) |=> !res_valid);
    p_seq_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !pkt_done |=> $stable(seq_tag));
endmodule

// File: rtl/bpbus_central.sv
module bpbus_central
    import bpbus_pkg::*;
#(
    parameter int N_PORTS  = 4,
    parameter int DATA_W   = 256,
    parameter int MAX_PEND = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_PORTS-1:0] req,
    input  logic [N_PORTS-1:0] bp,
    output logic [N_PORTS-1:0] gnt,
    output logic               bus_busy,
    input  logic [DATA_W-1:0]  din,
    input  logic               din_valid,
    input  logic               din_eop,
    output logic               bus_valid,
    output logic [DATA_W-1:0]  bus_data,
    output logic               bus_eop,
    output logic [3:0]         bus_tag,
    input  logic               lk_valid,
    input  logic               lk_fwd,
    input  logic [47:0]        lk_mac,
    input  logic [1:0]         lk_queue,
    input  logic [2:0]         lk_cos,
    input  logic [5:0]         lk_dscp,
    output logic               res_valid,
    output logic [63:0]        res_word
);
    logic             pkt_done;
    logic             full;
    logic             allow;
    logic [TAG_W-1:0] seq_tag;

    assign allow = !full && (bp == '0);

    bpbus_fsm #(.N_PORTS(N_PORTS), .DATA_W(DATA_W)) fsm_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (req),
        .allow     (allow),
        .din       (din),
        .din_valid (din_valid),
        .din_eop   (din_eop),
        .seq_tag   (seq_tag),
        .gnt       (gnt),
        .busy      (bus_busy),
        .pkt_done  (pkt_done),
        .bus_valid (bus_valid),
        .bus_data  (bus_data),
        .bus_eop   (bus_eop),
        .bus_tag   (bus_tag)
    );

    bpbus_pend_track #(.MAX_PEND(MAX_PEND)) trk_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .pkt_done  (pkt_done),
        .lk_valid  (lk_valid),
        .lk_fwd    (lk_fwd),
        .lk_mac    (lk_mac),
        .lk_queue  (lk_queue),
        .lk_cos    (lk_cos),
        .lk_dscp   (lk_dscp),
        .seq_tag   (seq_tag),
        .full      (full),
        .res_valid (res_valid),
        .res_word  (res_word)
    );

    p_busy_grant_r2: assert property (@(posedge clk) disable iff (!rst_n)
        bus_busy == (gnt != '0));
endmodule

// File: tb/bpbus_central_tb_top.sv
module bpbus_central_tb_top;
    localparam int N  = 4;
    localparam int DW = 256;
    localparam int MP = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  req = '0, bp = '0, gnt;
    logic          bus_busy;
    logic [DW-1:0] din = '0, bus_data;
    logic          din_valid = 1'b0, din_eop = 1'b0;
    logic          bus_valid, bus_eop;
    logic [3:0]    bus_tag;
    logic          lk_valid = 1'b0, lk_fwd = 1'b0;
    logic [47:0]   lk_mac = '0;
    logic [1:0]    lk_queue = '0;
    logic [2:0]    lk_cos = '0;
    logic [5:0]    lk_dscp = '0;
    logic          res_valid;
    logic [63:0]   res_word;

    int errors = 0;
    int checks = 0;
    int exp_last = N - 1;
    int exp_seq = 0;
    int exp_out = 0;

    always #2 clk = ~clk;

    bpbus_central #(.N_PORTS(N), .DATA_W(DW), .MAX_PEND(MP)) dut_i (
        .clk(clk), .rst_n(rst_n), .req(req), .bp(bp), .gnt(gnt),
        .bus_busy(bus_busy), .din(din), .din_valid(din_valid),
        .din_eop(din_eop), .bus_valid(bus_valid), .bus_data(bus_data),
        .bus_eop(bus_eop), .bus_tag(bus_tag), .lk_valid(lk_valid),
        .lk_fwd(lk_fwd), .lk_mac(lk_mac), .lk_queue(lk_queue),
        .lk_cos(lk_cos), .lk_dscp(lk_dscp), .res_valid(res_valid),
        .res_word(res_word)
    );

    function automatic int rr_pick(logic [N-1:0] m, int last);
        for (int k = 1; k <= N; k++) begin
            if (m[(last + k) % N]) return (last + k) % N;
        end
        return -1;
    endfunction

    function automatic logic [63:0] res_pack(logic [3:0] t, logic f, logic [5:0] d,
                                             logic [2:0] c, logic [1:0] q, logic [47:0] m);
        return {t, f, d, c, q, m};
    endfunction

    task automatic chk(bit ok, string rq, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", rq, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic send_packet(logic [N-1:0] m, int nbeats, bit gaps);
        int w;
        logic [N-1:0] wo;
        logic [DW-1:0] beat;
        w  = rr_pick(m, exp_last);
        wo = N'(1) << w;
        req = m;
        tick();
        chk(gnt == wo, "R3 grant", 64'(gnt), 64'(wo));
        chk(bus_busy == 1'b1, "R2 busy", 64'(bus_busy), 64'd1);
        exp_last = w;
        for (int b = 0; b < nbeats; b++) begin
            if (gaps && ($urandom % 3 == 0)) begin
                req = '1;
                din_valid = 1'b0;
                tick();
                chk(bus_valid == 1'b0, "R4 gap", 64'(bus_valid), 64'd0);
                chk(gnt == wo, "R2 hold", 64'(gnt), 64'(wo));
            end
            beat = {8{$urandom}};
            din = beat;
            din_valid = 1'b1;
            din_eop = (b == nbeats - 1);
            tick();
            chk(bus_valid == 1'b1 && bus_data == beat, "R4 data",
                bus_data[63:0], beat[63:0]);
            chk(bus_eop == (b == nbeats - 1), "R4 eop", 64'(bus_eop),
                64'(b == nbeats - 1));
            chk(bus_tag == 4'(exp_seq), "R5 tag", 64'(bus_tag), 64'(4'(exp_seq)));
            if (b == nbeats - 1)
                chk(gnt == '0, "R6 release", 64'(gnt), 64'd0);
            else
                chk(gnt == wo, "R2 hold", 64'(gnt), 64'(wo));
        end
        din_valid = 1'b0;
        din_eop = 1'b0;
        req = '0;
        exp_seq = (exp_seq + 1) % 16;
        exp_out++;
    endtask

    task automatic give_result();
        logic f;
        logic [5:0] d;
        logic [2:0] c;
        logic [1:0] q;
        logic [47:0] m;
        logic [63:0] e;
        f = 1'($urandom); d = 6'($urandom); c = 3'($urandom);
        q = 2'($urandom); m = {16'($urandom), 32'($urandom)};
        lk_fwd = f; lk_dscp = d; lk_cos = c; lk_queue = q; lk_mac = m;
        lk_valid = 1'b1;
        tick();
        lk_valid = 1'b0;
        if (exp_out > 0) begin
            e = res_pack(4'((exp_seq - exp_out + 16) % 16), f, d, c, q, m);
            chk(res_valid == 1'b1 && res_word == e, "R9 result", res_word, e);
            exp_out--;
        end else begin
            chk(res_valid == 1'b0, "R10 ignored", 64'(res_valid), 64'd0);
        end
        tick();
        chk(res_valid == 1'b0, "R9 pulse", 64'(res_valid), 64'd0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_0042));
        #1;
        chk(gnt == '0 && bus_valid == 1'b0 && res_valid == 1'b0 && bus_busy == 1'b0,
            "R1 reset", {gnt, bus_valid, res_valid, bus_busy}, 64'd0);
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        chk(gnt == '0 && bus_eop == 1'b0, "R1 after reset", 64'(gnt), 64'd0);

        din = '1; din_valid = 1'b1; din_eop = 1'b1;
        tick();
        chk(bus_valid == 1'b0 && gnt == '0, "R4 ignored idle", 64'(bus_valid), 64'd0);
        din_valid = 1'b0; din_eop = 1'b0;

        give_result();

        send_packet(4'b0110, 3, 1'b0);
        send_packet(4'b0111, 1, 1'b0);
        send_packet(4'b0011, 2, 1'b0);
        chk(exp_last == 0, "R3 wrap", 64'(exp_last), 64'd0);
        give_result();
        give_result();
        give_result();
        give_result();

        bp = 4'b1000; req = 4'b0101;
        repeat (3) begin
            tick();
            chk(gnt == '0, "R7 backpressure", 64'(gnt), 64'd0);
        end
        bp = '0;
        send_packet(4'b0101, 2, 1'b0);
        give_result();

        for (int i = 0; i < MP; i++) send_packet(4'b1111, 1, 1'b0);
        req = 4'b1001;
        repeat (3) begin
            tick();
            chk(gnt == '0, "R8 full", 64'(gnt), 64'd0);
        end
        give_result();
        send_packet(4'b1001, 2, 1'b0);
        while (exp_out > 0) give_result();

        for (int i = 0; i < 60; i++) begin
            logic [N-1:0] m;
            m = N'($urandom);
            if (m == '0) m = 4'b0001;
            if (exp_out == MP) give_result();
            send_packet(m, 1 + int'($urandom % 4), 1'b1);
            if ($urandom % 2 == 0) give_result();
        end
        while (exp_out > 0) give_result();
        give_result();

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule